// File: doc/BRIEF.md
# Transceiver Reconfiguration Command Sequencer

This block sits between a command source and a memory-mapped transceiver reconfiguration controller. It turns three high-level commands into fixed, ordered register recipes on a simple bus: stream a stored configuration image (streamer mode 0), set the transmitter output-swing level, and read that level back. Each command carries a logical channel number and an argument. The argument is the image base address for streaming and the swing level for a level write. The block acts as bus master: it drives address, write data and the write or read strobe, and it holds them while the slave stalls.

After the last write of a recipe, the block waits for the external reconfiguration-busy signal to fall. A programmable cycle limit bounds that wait. After a streaming operation it then pulses a channel reset request and raises the word-alignment request from 0 to 1, so that the receiver locks onto the new word boundary. It signals completion with a one-cycle done pulse and an error flag. Commands with bad arguments are refused before any bus cycle. Commands that arrive while the block cannot take them are dropped and flagged.

Top module: `xcvr_reconf_seq`

## Requirements
- R1: A stream command (cmd_op = 0) issues exactly eight writes, as (address, data) pairs in this order: (0x38, channel), (0x3A, 0), (0x3B, 0), (0x3C, base), (0x3A, 1), (0x3B, 1), (0x3C, 1), (0x3A, 1). It then completes with error low.
- R2: A stream command whose base address equals the controller base (parameter, default 0x0000) or the bus-master base (parameter, default 0x0800) performs no bus cycle, does not pulse the channel reset, and completes with error high.
- R3: A level-write command (cmd_op = 1) with level 0 to 63 issues exactly four writes in this order: (0x08, channel), (0x0B, 0), (0x0C, level), (0x0A, 1). It completes with error low.
- R4: A level-write command whose level exceeds 63 performs no bus cycle and completes with error high.
- R5: A level-read command (cmd_op = 2) issues the writes (0x08, channel), (0x0B, 0) and (0x0A, 2), and then one read of 0x0C. It completes with rd_level equal to bits 5:0 of the read data.
- R6: While waitrequest is high, every bus access keeps its address, write data and strobe unchanged. The access completes in the first cycle in which waitrequest is low, and write and read are never high together.
- R7: After the busy wait of a stream command, chan_reset is high for exactly one cycle while align_req is 0. align_req then rises to 1, and only after that is done reported.
- R8: A command is accepted only when the block is idle and reconf_busy_i is low. Otherwise cmd_ignored pulses in the next cycle, and the command causes no bus cycle and no change in progress.
- R9: After the last recipe write, the block waits while reconf_busy_i is high. If reconf_busy_i is still high after poll_limit waiting cycles, the command completes with error high and performs no further bus access or channel reset.
- R10: cmd_op = 3 is reserved. It performs no bus cycle and completes with error high.
- R11: During and right after reset, busy, done, error, av_write, av_read, chan_reset, align_req and cmd_ignored are all low. done is a one-cycle pulse, and error holds until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 stream, 1 level write, 2 level read, 3 reserved |
| cmd_chan | input | CH_W | Logical channel number |
| cmd_arg | input | ARG_W | Image base address or swing level |
| poll_limit | input | TW | Maximum cycles to wait on reconf_busy_i |
| reconf_busy_i | input | 1 | Reconfiguration controller busy |
| av_address | output | AW | Bus word address |
| av_writedata | output | DW | Bus write data |
| av_write | output | 1 | Write strobe |
| av_read | output | 1 | Read strobe |
| av_readdata | input | DW | Bus read data |
| av_waitrequest | input | 1 | Slave stall |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last command failed |
| cmd_ignored | output | 1 | One-cycle pulse: command dropped |
| rd_level | output | LVL_W | Level returned by a level read |
| chan_reset | output | 1 | Channel reset request pulse |
| align_req | output | 1 | Word-alignment request |

## Verification
The level write is swept over every legal level and several out-of-range levels, with the channel and the slave stall length varied. This separates the accepted range from the refused range right at the 63/64 boundary. The level read is swept over all 64 codes with junk in the upper read-data bits, which shows that the returned value comes from the read data and is masked to six bits. Streams are run with ordinary and reserved base addresses, which separates a full recipe followed by reset and realign from a refusal that issues no bus cycle. A busy signal held high, and commands sent while the block is busy, exercise the timeout and the ignore paths.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
   typedef enum logic [1:0] {
      OP_STREAM = 2'd0,
      OP_VOD_WR = 2'd1,
      OP_VOD_RD = 2'd2,
      OP_RSVD   = 2'd3
   } xrs_op_e;

   typedef enum logic [3:0] {
      S_IDLE, S_ISSUE, S_WAIT, S_POLL, S_RDI, S_RDW, S_RST, S_ALIGN, S_FIN
   } xrs_state_e;

   // register offsets decoded by the reconfiguration controller
   localparam int unsigned ANA_CH  = 32'h08;
   localparam int unsigned ANA_CSR = 32'h0A;
   localparam int unsigned ANA_OFS = 32'h0B;
   localparam int unsigned ANA_DAT = 32'h0C;
   localparam int unsigned STR_CH  = 32'h38;
   localparam int unsigned STR_CSR = 32'h3A;
   localparam int unsigned STR_OFS = 32'h3B;
   localparam int unsigned STR_DAT = 32'h3C;
   localparam int unsigned MIN_AW  = 7;
endpackage

// File: rtl/xrs_recipe.sv
module xrs_recipe
   import xrs_pkg::*;
#(
   parameter int AW    = 7,
   parameter int DW    = 32,
   parameter int CH_W  = 10,
   parameter int ARG_W = 16
) (
   input  xrs_op_e          op,
   input  logic [2:0]       step,
   input  logic [CH_W-1:0]  chan,
   input  logic [ARG_W-1:0] arg,
   output logic [AW-1:0]    addr,
   output logic [DW-1:0]    wdata,
   output logic             last
);
   always_comb begin
      addr  = '0;
      wdata = '0;
      last  = 1'b0;
      unique case (op)
         OP_STREAM: begin
            unique case (step)
               3'd0: begin addr = AW'(STR_CH);  wdata = DW'(chan); end
               3'd1: begin addr = AW'(STR_CSR); wdata = '0;        end
               3'd2: begin addr = AW'(STR_OFS); wdata = '0;        end
               3'd3: begin addr = AW'(STR_DAT); wdata = DW'(arg);  end
               3'd4: begin addr = AW'(STR_CSR); wdata = DW'(1);    end
               3'd5: begin addr = AW'(STR_OFS); wdata = DW'(1);    end
               3'd6: begin addr = AW'(STR_DAT); wdata = DW'(1);    end
               default: begin addr = AW'(STR_CSR); wdata = DW'(1); last = 1'b1; end
            endcase
         end
         OP_VOD_WR: begin
            unique case (step)
               3'd0: begin addr = AW'(ANA_CH);  wdata = DW'(chan); end
               3'd1: begin addr = AW'(ANA_OFS); wdata = '0;        end
               3'd2: begin addr = AW'(ANA_DAT); wdata = DW'(arg);  end
               default: begin addr = AW'(ANA_CSR); wdata = DW'(1); last = 1'b1; end
            endcase
         end
         default: begin
            unique case (step)
               3'd0: begin addr = AW'(ANA_CH);  wdata = DW'(chan); end
               3'd1: begin addr = AW'(ANA_OFS); wdata = '0;        end
               default: begin addr = AW'(ANA_CSR); wdata = DW'(2); last = 1'b1; end
            endcase
         end
      endcase
   end
endmodule

// File: rtl/xrs_bus.sv
module xrs_bus #(
   parameter int AW = 7,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          st_rd,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   input  logic          av_waitrequest,
   output logic [AW-1:0] av_address,
   output logic [DW-1:0] av_writedata,
   output logic          av_write,
   output logic          av_read,
   output logic          ack
);
   logic          act_q, rd_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         rd_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (start && !act_q) begin
         act_q  <= 1'b1;
         rd_q   <= st_rd;
         addr_q <= st_addr;
         data_q <= st_data;
      end else if (ack) begin
         act_q  <= 1'b0;
      end
   end

   assign ack          = act_q && !av_waitrequest;
   assign av_address   = addr_q;
   assign av_writedata = data_q;
   assign av_write     = act_q && !rd_q;
   assign av_read      = act_q && rd_q;

   // R6: a stalled access keeps its address, data and strobe
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (av_write || av_read) && av_waitrequest |=>
         $stable(av_address) && $stable(av_writedata) &&
         $stable(av_write) && $stable(av_read));

   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(av_write && av_read));
endmodule

// File: rtl/xcvr_reconf_seq.sv
module xcvr_reconf_seq
   import xrs_pkg::*;
#(
   parameter int             AW          = 7,
   parameter int             DW          = 32,
   parameter int             CH_W        = 10,
   parameter int             ARG_W       = 16,
   parameter int             TW          = 16,
   parameter int             VOD_MAX     = 63,
   parameter int             LVL_W       = $clog2(VOD_MAX + 1),
   parameter logic [ARG_W-1:0] CTRL_BASE   = 16'h0000,
   parameter logic [ARG_W-1:0] MASTER_BASE = 16'h0800
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [CH_W-1:0]  cmd_chan,
   input  logic [ARG_W-1:0] cmd_arg,
   input  logic [TW-1:0]    poll_limit,
   input  logic             reconf_busy_i,
   output logic [AW-1:0]    av_address,
   output logic [DW-1:0]    av_writedata,
   output logic             av_write,
   output logic             av_read,
   input  logic [DW-1:0]    av_readdata,
   input  logic             av_waitrequest,
   output logic             busy,
   output logic             done,
   output logic             error,
   output logic             cmd_ignored,
   output logic [LVL_W-1:0] rd_level,
   output logic             chan_reset,
   output logic             align_req
);
   if (AW < int'(MIN_AW)) begin : g_chk_aw
      $error("AW too small for controller offsets");
   end
   if (DW < ARG_W || DW < CH_W || DW < LVL_W) begin : g_chk_dw
      $error("DW must hold channel, argument and level");
   end
   if (ARG_W < LVL_W) begin : g_chk_arg
      $error("ARG_W must hold a level");
   end

   xrs_state_e       state;
   xrs_op_e          op_q, op_in;
   logic [CH_W-1:0]  chan_q;
   logic [ARG_W-1:0] arg_q;
   logic [2:0]       step_q;
   logic [TW-1:0]    pcnt_q;
   logic             err_q, align_q, ign_q;
   logic [LVL_W-1:0] lvl_q;

   logic             accept, bad_cmd;
   logic [AW-1:0]    rc_addr;
   logic [DW-1:0]    rc_data;
   logic             rc_last, bus_ack, bus_start, bus_rd;

   assign op_in  = xrs_op_e'(cmd_op);
   assign accept = cmd_valid && (state == S_IDLE) && !reconf_busy_i;
   always_comb begin
      unique case (op_in)
         OP_STREAM: bad_cmd = (cmd_arg == CTRL_BASE) || (cmd_arg == MASTER_BASE);
         OP_VOD_WR: bad_cmd = cmd_arg > ARG_W'(VOD_MAX);
         OP_VOD_RD: bad_cmd = 1'b0;
         default:   bad_cmd = 1'b1;
      endcase
   end

   xrs_recipe #(.AW(AW), .DW(DW), .CH_W(CH_W), .ARG_W(ARG_W)) recipe_i (
      .op(op_q), .step(step_q), .chan(chan_q), .arg(arg_q),
      .addr(rc_addr), .wdata(rc_data), .last(rc_last)
   );

   assign bus_start = (state == S_ISSUE) || (state == S_RDI);
   assign bus_rd    = (state == S_RDI);

   xrs_bus #(.AW(AW), .DW(DW)) bus_i (
      .clk(clk), .rst_n(rst_n), .start(bus_start), .st_rd(bus_rd),
      .st_addr(bus_rd ? AW'(ANA_DAT) : rc_addr), .st_data(rc_data),
      .av_waitrequest(av_waitrequest), .av_address(av_address),
      .av_writedata(av_writedata), .av_write(av_write), .av_read(av_read),
      .ack(bus_ack)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         op_q    <= OP_STREAM;
         chan_q  <= '0;
         arg_q   <= '0;
         step_q  <= '0;
         pcnt_q  <= '0;
         err_q   <= 1'b0;
         align_q <= 1'b0;
         ign_q   <= 1'b0;
         lvl_q   <= '0;
      end else begin
         ign_q <= cmd_valid && !accept;
         unique case (state)
            S_IDLE: if (accept) begin
               op_q   <= op_in;
               chan_q <= cmd_chan;
               arg_q  <= cmd_arg;
               step_q <= '0;
               err_q  <= bad_cmd;
               if (bad_cmd) state <= S_FIN;
               else begin
                  state <= S_ISSUE;
                  if (op_in == OP_STREAM) align_q <= 1'b0;
               end
            end
            S_ISSUE: state <= S_WAIT;
            S_WAIT: if (bus_ack) begin
               if (rc_last) begin
                  state  <= S_POLL;
                  pcnt_q <= '0;
               end else begin
                  step_q <= step_q + 3'd1;
                  state  <= S_ISSUE;
               end
            end
            S_POLL: begin
               if (!reconf_busy_i) begin
                  if (op_q == OP_VOD_RD)      state <= S_RDI;
                  else if (op_q == OP_STREAM) state <= S_RST;
                  else                        state <= S_FIN;
               end else if (pcnt_q >= poll_limit) begin
                  err_q <= 1'b1;
                  state <= S_FIN;
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
               end
            end
            S_RDI: state <= S_RDW;
            S_RDW: if (bus_ack) begin
               lvl_q <= av_readdata[LVL_W-1:0];
               state <= S_FIN;
            end
            S_RST: state <= S_ALIGN;
            S_ALIGN: begin
               align_q <= 1'b1;
               state   <= S_FIN;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy        = (state != S_IDLE);
   assign done        = (state == S_FIN);
   assign error       = err_q;
   assign cmd_ignored = ign_q;
   assign rd_level    = lvl_q;
   assign chan_reset  = (state == S_RST);
   assign align_req   = align_q;

   // R4: an out-of-range level finishes at once with no bus strobe
   p_bad_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (op_in == OP_VOD_WR) && (cmd_arg > ARG_W'(VOD_MAX)) |=>
         done && error && !av_write && !av_read);

   // R8: a command refused for external busy leaves the block idle
   p_ignore_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !busy && reconf_busy_i |=> !busy && !av_write && !av_read);

   // R7: the alignment request rises two cycles after the reset pulse
   p_align_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(align_req) |-> $past(chan_reset, 2) && done);

   // R11: done is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: no bus access is in flight while waiting on the busy input
   p_poll_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_POLL) |-> !av_write && !av_read);
endmodule

// File: tb/xcvr_reconf_seq_tb_top.sv
`timescale 1ns/1ps
module xcvr_reconf_seq_tb_top;
   localparam int AW = 7, DW = 32, CH_W = 10, ARG_W = 16, TW = 16, LVL_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [1:0]       cmd_op = '0;
   logic [CH_W-1:0]  cmd_chan = '0;
   logic [ARG_W-1:0] cmd_arg = '0;
   logic [TW-1:0]    poll_limit = 16'd20;
   logic             reconf_busy_i;
   logic [AW-1:0]    av_address;
   logic [DW-1:0]    av_writedata;
   logic             av_write, av_read;
   logic [DW-1:0]    av_readdata;
   logic             av_waitrequest;
   logic             busy, done, error, cmd_ignored, chan_reset, align_req;
   logic [LVL_W-1:0] rd_level;

   always #2 clk = ~clk;

   xcvr_reconf_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_chan(cmd_chan), .cmd_arg(cmd_arg), .poll_limit(poll_limit),
      .reconf_busy_i(reconf_busy_i), .av_address(av_address),
      .av_writedata(av_writedata), .av_write(av_write), .av_read(av_read),
      .av_readdata(av_readdata), .av_waitrequest(av_waitrequest),
      .busy(busy), .done(done), .error(error), .cmd_ignored(cmd_ignored),
      .rd_level(rd_level), .chan_reset(chan_reset), .align_req(align_req)
   );

   // slave model
   int          wait_len = 0, wcnt = 0, busy_len = 5, busy_cnt = 0;
   logic        stuck = 1'b0;
   logic [5:0]  rd_val = '0;
   int          wr_n = 0, rd_n = 0, rst_cnt = 0;
   logic [31:0] lg_addr [0:15];
   logic [31:0] lg_data [0:15];
   logic [31:0] lg_raddr = '0;
   logic        align_at_rst = 1'b0;

   assign av_waitrequest = (av_write || av_read) && (wcnt < wait_len);
   assign reconf_busy_i  = stuck || (busy_cnt != 0);
   assign av_readdata    = {26'h2A5A5A5, rd_val};

   always @(posedge clk) begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if ((av_write || av_read) && av_waitrequest) wcnt <= wcnt + 1;
      if ((av_write || av_read) && !av_waitrequest) begin
         wcnt <= 0;
         if (av_write) begin
            if (wr_n < 16) begin
               lg_addr[wr_n] <= 32'(av_address);
               lg_data[wr_n] <= av_writedata;
            end
            wr_n <= wr_n + 1;
            if (av_writedata[1:0] != 2'b00 &&
                (av_address == 7'h0A || av_address == 7'h3A))
               busy_cnt <= busy_len;
         end else begin
            rd_n     <= rd_n + 1;
            lg_raddr <= 32'(av_address);
         end
      end
      if (chan_reset) begin
         rst_cnt      <= rst_cnt + 1;
         align_at_rst <= align_req;
      end
   end

   int n_chk = 0, n_fail = 0;
   logic finished = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   logic [31:0] ex_addr [0:15];
   logic [31:0] ex_data [0:15];
   int          ex_n = 0;

   task automatic ex_add(input logic [31:0] a, input logic [31:0] d);
      ex_addr[ex_n] = a;
      ex_data[ex_n] = d;
      ex_n++;
   endtask

   task automatic build(input logic [1:0] op, input logic [CH_W-1:0] ch, input logic [ARG_W-1:0] arg);
      ex_n = 0;
      if (op == 2'd0) begin
         ex_add(32'h38, 32'(ch)); ex_add(32'h3A, 0); ex_add(32'h3B, 0);
         ex_add(32'h3C, 32'(arg)); ex_add(32'h3A, 1); ex_add(32'h3B, 1);
         ex_add(32'h3C, 1); ex_add(32'h3A, 1);
      end else begin
         ex_add(32'h08, 32'(ch)); ex_add(32'h0B, 0);
         if (op == 2'd1) begin
            ex_add(32'h0C, 32'(arg)); ex_add(32'h0A, 1);
         end else begin
            ex_add(32'h0A, 2);
         end
      end
   endtask

   task automatic cmp_log(input string req);
      int bad = 0;
      check({req, " write count"}, 32'(wr_n), 32'(ex_n));
      for (int i = 0; i < ex_n && i < wr_n; i++)
         if (lg_addr[i] !== ex_addr[i] || lg_data[i] !== ex_data[i]) bad++;
      check({req, " write sequence mismatches"}, 32'(bad), 0);
   endtask

   task automatic clear_log();
      wr_n = 0; rd_n = 0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (!done) check("R11 done seen", 0, 1);
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [CH_W-1:0] ch, input logic [ARG_W-1:0] arg);
      @(negedge clk);
      clear_log();
      cmd_op = op; cmd_chan = ch; cmd_arg = arg; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 outputs in reset",
            32'({busy, done, error, av_write, av_read, chan_reset, align_req, cmd_ignored}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 outputs after reset",
            32'({busy, done, error, av_write, av_read, chan_reset, align_req, cmd_ignored}), 0);

      // R1 / R7 streams with several bases, channels and stall lengths
      for (int k = 0; k < 3; k++) begin
         logic [ARG_W-1:0] base;
         int r0;
         base = (k == 0) ? 16'h8000 : (k == 1) ? 16'h1234 : 16'hFFFF;
         wait_len = k;
         r0 = rst_cnt;
         build(2'd0, CH_W'(k * 3), base);
         run_cmd(2'd0, CH_W'(k * 3), base);
         check("R1 stream error", 32'(error), 0);
         check("R7 align_req at done", 32'(align_req), 1);
         @(negedge clk);
         cmp_log("R1 stream");
         check("R7 one reset pulse", 32'(rst_cnt - r0), 1);
         check("R7 align low during reset", 32'(align_at_rst), 0);
      end

      // R2 reserved bases
      for (int k = 0; k < 2; k++) begin
         int r0;
         r0 = rst_cnt;
         run_cmd(2'd0, 10'd1, (k == 0) ? 16'h0000 : 16'h0800);
         check("R2 reserved base error", 32'(error), 1);
         @(negedge clk);
         check("R2 no bus cycle", 32'(wr_n + rd_n), 0);
         check("R2 no reset pulse", 32'(rst_cnt - r0), 0);
      end

      // R3 / R4 level sweep across and beyond the legal range
      for (int lv = 0; lv < 70; lv++) begin
         logic [ARG_W-1:0] a;
         a = (lv < 68) ? ARG_W'(lv) : (lv == 68) ? 16'h0100 : 16'hFFFF;
         wait_len = lv % 3;
         build(2'd1, CH_W'(lv * 5), a);
         run_cmd(2'd1, CH_W'(lv * 5), a);
         if (a <= 16'd63) begin
            check("R3 level write error", 32'(error), 0);
            @(negedge clk);
            cmp_log("R3 level write");
         end else begin
            check("R4 bad level error", 32'(error), 1);
            @(negedge clk);
            check("R4 no bus cycle", 32'(wr_n + rd_n), 0);
         end
      end

      // R5 read-back sweep
      for (int lv = 0; lv < 64; lv++) begin
         rd_val = 6'(lv);
         wait_len = (lv + 1) % 3;
         build(2'd2, CH_W'(lv), '0);
         run_cmd(2'd2, CH_W'(lv), '0);
         check("R5 read error", 32'(error), 0);
         check("R5 returned level", 32'(rd_level), 32'(lv));
         @(negedge clk);
         cmp_log("R5 read writes");
         check("R5 one read", 32'(rd_n), 1);
         check("R5 read address", lg_raddr, 32'h0C);
      end
      wait_len = 0;

      // R10 reserved op
      run_cmd(2'd3, 10'd2, 16'h0005);
      check("R10 reserved op error", 32'(error), 1);
      @(negedge clk);
      check("R10 no bus cycle", 32'(wr_n + rd_n), 0);

      // R8 command while busy
      @(negedge clk);
      clear_log();
      build(2'd0, 10'd7, 16'h8000);
      cmd_op = 2'd0; cmd_chan = 10'd7; cmd_arg = 16'h8000; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (3) @(negedge clk);
      cmd_op = 2'd1; cmd_chan = 10'd1; cmd_arg = 16'd9; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R8 ignored while busy", 32'(cmd_ignored), 1);
      wait_done();
      @(negedge clk);
      cmp_log("R8 stream unaffected");

      // R8 command while external busy is high
      @(negedge clk);
      clear_log();
      stuck = 1'b1;
      cmd_op = 2'd1; cmd_chan = 10'd1; cmd_arg = 16'd9; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R8 ignored on external busy", 32'(cmd_ignored), 1);
      check("R8 stays idle", 32'(busy), 0);
      stuck = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 no bus cycle", 32'(wr_n + rd_n), 0);

      // R9 timeout
      @(negedge clk);
      clear_log();
      cmd_op = 2'd1; cmd_chan = 10'd3; cmd_arg = 16'd17; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      stuck = 1'b1;
      wait_done();
      check("R9 timeout error", 32'(error), 1);
      @(negedge clk);
      check("R9 writes before timeout", 32'(wr_n), 4);
      check("R9 no read", 32'(rd_n), 0);
      stuck = 1'b0;
      repeat (2) @(negedge clk);
      run_cmd(2'd1, 10'd3, 16'd17);
      check("R11 error clears on next command", 32'(error), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule